// File: doc/BRIEF.md
# Horizontal Line Segment Decoder

This block turns the running clock count of one sensor line (2640 clocks long) into a set of registered tags and windows. The pixel capture logic downstream uses them. A region tag marks each output position as optical-black reference, dummy pre-scan, active image or blanking. A one-hot stage vector opens the vertical-transfer windows inside the horizontal blanking gap. A separate window marks where the overflow-drain shutter pulse may be placed. A gating enable tells the pixel-rate clock generator when horizontal shifting is allowed.

The vertical-transfer stage timing depends on the accumulation mode. In field mode each stage slot is 28 clocks long, and a stage-select input chooses whether three or four stages are used. In frame mode each slot is 56 clocks long, and three stages are always used. All slots start at the same fixed position in the blanking gap. Every output is registered, so each output describes the count that was presented one clock earlier. It therefore lines up with the first pixel of each region.

Top module: `seg_line_decoder`

## Requirements
- R1: While rst_n is low, at the next clock edge every output goes to zero: the region tag is 0 (blanking) and the stage vector, vt_en_o, ofd_win_o and hclk_en_o are all 0. The line count input has no effect on this.
- R2: Every output is registered with exactly one clock of latency. The outputs seen after an edge describe the count, mode and stage-select sampled at that edge, even when the count jumps or the mode changes in the middle of a line.
- R3: region_o uses this encoding: 0 is blanking, 1 is optical black, 2 is dummy pre-scan and 3 is active. The mapping by count is: 0..53 gives 1, 278..301 gives 2, 302..303 gives 1, and 304..2399 gives 3. Every other count, including any count of 2640 or more, gives 0.
- R4: In field mode (frame_mode_i=0), bit k of vt_stage_o is high exactly for the counts 54+28k to 81+28k.
- R5: In field mode, four_stage_i=1 enables stages 0..3, so the windows end at count 165. four_stage_i=0 enables stages 0..2, so the windows end at count 137.
- R6: In frame mode (frame_mode_i=1), bit k of vt_stage_o is high for the counts 54+56k to 109+56k, for k=0..2. This gives three stages that end at count 221. In this mode four_stage_i has no effect.
- R7: vt_stage_o never has more than one bit set. vt_en_o is high exactly when some stage bit is high.
- R8: ofd_win_o is high exactly for the counts 152..207, in both modes.
- R9: hclk_en_o is high for the counts 0..53 and 278..2639, and low for every other count.
- R10: vt_en_o and hclk_en_o are never high together. ofd_win_o is never high together with hclk_en_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_cnt_i | input | 12 | Clock position within the current line |
| frame_mode_i | input | 1 | 1 selects frame accumulation timing, 0 selects field timing |
| four_stage_i | input | 1 | Field mode only: 1 selects four transfer stages, 0 selects three |
| region_o | output | 2 | Registered region tag (encoding in R3) |
| vt_stage_o | output | 4 | Registered one-hot vertical-transfer stage window |
| vt_en_o | output | 1 | High while any transfer stage window is open |
| ofd_win_o | output | 1 | Overflow-drain shutter pulse window |
| hclk_en_o | output | 1 | Enable for horizontal shift and reset-gate clocking |

## Verification
The main stimulus is a set of full sequential line sweeps, one for each timing variant: field mode with four stages, field mode with three stages, and frame mode with the stage select set both ways. Comparing these sweeps separates the 28-clock slots from the 56-clock slots. It also shows where the last stage ends in each variant and proves that the stage select is ignored in frame mode. A run of pseudo-random counts, with the mode changing between cycles, separates a correct single-cycle registration from logic that depends on the previous count. Counts of 2640 and above check that positions outside the line fall back to blanking. A held-reset phase with an in-line count applied shows that reset wins over the decode.

// File: rtl/seg_line_pkg.sv
package seg_line_pkg;

  typedef enum logic [1:0] {
    RG_BLANK  = 2'd0,
    RG_OB     = 2'd1,
    RG_DUMMY  = 2'd2,
    RG_ACTIVE = 2'd3
  } region_t;

  // true when c lies in the half-open span [lo, lo+len)
  function automatic bit in_win(int c, int lo, int len);
    return (c >= lo) && (c < lo + len);
  endfunction

  // number of transfer stages in use for a given mode
  function automatic int stages_used(bit frame, bit four, int max_st, int frame_st);
    if (frame) return frame_st;
    return four ? max_st : max_st - 1;
  endfunction

endpackage

// File: rtl/seg_region_dec.sv
module seg_region_dec
  import seg_line_pkg::*;
#(
  parameter int CNT_W        = 12,
  parameter int LINE_LEN     = 2640,
  parameter int OB_REAR      = 54,
  parameter int SHIFT_RESUME = 278,
  parameter int DUMMY        = 24,
  parameter int OB_FRONT     = 2,
  parameter int ACTIVE       = 2096
) (
  input  logic [CNT_W-1:0] cnt,
  output region_t          rg
);
  localparam int DUMMY_LO = SHIFT_RESUME;
  localparam int OBF_LO   = DUMMY_LO + DUMMY;
  localparam int ACT_LO   = OBF_LO + OB_FRONT;

  int c;
  assign c = int'(cnt);

  always_comb begin
    rg = RG_BLANK;
    if (c < LINE_LEN) begin
      if (in_win(c, 0, OB_REAR))             rg = RG_OB;
      else if (in_win(c, DUMMY_LO, DUMMY))   rg = RG_DUMMY;
      else if (in_win(c, OBF_LO, OB_FRONT))  rg = RG_OB;
      else if (in_win(c, ACT_LO, ACTIVE))    rg = RG_ACTIVE;
    end
  end

endmodule

// File: rtl/seg_vt_win.sv
module seg_vt_win
  import seg_line_pkg::*;
#(
  parameter int CNT_W        = 12,
  parameter int VT_START     = 54,
  parameter int SLOT_FIELD   = 28,
  parameter int SLOT_FRAME   = 56,
  parameter int MAX_STAGES   = 4,
  parameter int FRAME_STAGES = 3
) (
  input  logic [CNT_W-1:0]      cnt,
  input  logic                  frame,
  input  logic                  four,
  output logic [MAX_STAGES-1:0] oh
);
  int c;
  int n_used;
  logic [MAX_STAGES-1:0] fld_oh;
  logic [MAX_STAGES-1:0] frm_oh;

  assign c      = int'(cnt);
  assign n_used = stages_used(frame, four, MAX_STAGES, FRAME_STAGES);

  for (genvar k = 0; k < MAX_STAGES; k++) begin : g_stage
    assign fld_oh[k] = (k < n_used) && in_win(c, VT_START + k*SLOT_FIELD, SLOT_FIELD);
    assign frm_oh[k] = (k < n_used) && in_win(c, VT_START + k*SLOT_FRAME, SLOT_FRAME);
  end

  assign oh = frame ? frm_oh : fld_oh;

endmodule

// File: rtl/seg_gate.sv
module seg_gate
  import seg_line_pkg::*;
#(
  parameter int CNT_W        = 12,
  parameter int LINE_LEN     = 2640,
  parameter int VT_START     = 54,
  parameter int SHIFT_RESUME = 278,
  parameter int OFD_START    = 152,
  parameter int OFD_END      = 208
) (
  input  logic [CNT_W-1:0] cnt,
  output logic             ofd,
  output logic             hclk
);
  localparam int GAP_LEN = SHIFT_RESUME - VT_START;
  localparam int OFD_LEN = OFD_END - OFD_START;

  int c;
  assign c    = int'(cnt);
  assign ofd  = in_win(c, OFD_START, OFD_LEN);
  assign hclk = (c < LINE_LEN) && !in_win(c, VT_START, GAP_LEN);

endmodule

// File: rtl/seg_line_decoder.sv
module seg_line_decoder
  import seg_line_pkg::*;
#(
  parameter int CNT_W        = 12,
  parameter int LINE_LEN     = 2640,
  parameter int OB_REAR      = 54,
  parameter int DUMMY        = 24,
  parameter int OB_FRONT     = 2,
  parameter int ACTIVE       = 2096,
  parameter int VT_START     = 54,
  parameter int SHIFT_RESUME = 278,
  parameter int SLOT_FIELD   = 28,
  parameter int SLOT_FRAME   = 56,
  parameter int MAX_STAGES   = 4,
  parameter int FRAME_STAGES = 3,
  parameter int OFD_START    = 152,
  parameter int OFD_END      = 208
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CNT_W-1:0]      line_cnt_i,
  input  logic                  frame_mode_i,
  input  logic                  four_stage_i,
  output logic [1:0]            region_o,
  output logic [MAX_STAGES-1:0] vt_stage_o,
  output logic                  vt_en_o,
  output logic                  ofd_win_o,
  output logic                  hclk_en_o
);
  // next-state decode results, named for visibility
  region_t               rg_d;
  logic [MAX_STAGES-1:0] oh_d;
  logic                  ofd_d;
  logic                  hclk_d;

  region_t               rg_q;
  logic [MAX_STAGES-1:0] oh_q;
  logic                  vten_q;
  logic                  ofd_q;
  logic                  hclk_q;

  seg_region_dec #(
    .CNT_W(CNT_W), .LINE_LEN(LINE_LEN), .OB_REAR(OB_REAR),
    .SHIFT_RESUME(SHIFT_RESUME), .DUMMY(DUMMY), .OB_FRONT(OB_FRONT),
    .ACTIVE(ACTIVE)
  ) u_region (
    .cnt (line_cnt_i),
    .rg  (rg_d)
  );

  seg_vt_win #(
    .CNT_W(CNT_W), .VT_START(VT_START), .SLOT_FIELD(SLOT_FIELD),
    .SLOT_FRAME(SLOT_FRAME), .MAX_STAGES(MAX_STAGES),
    .FRAME_STAGES(FRAME_STAGES)
  ) u_vt (
    .cnt   (line_cnt_i),
    .frame (frame_mode_i),
    .four  (four_stage_i),
    .oh    (oh_d)
  );

  seg_gate #(
    .CNT_W(CNT_W), .LINE_LEN(LINE_LEN), .VT_START(VT_START),
    .SHIFT_RESUME(SHIFT_RESUME), .OFD_START(OFD_START), .OFD_END(OFD_END)
  ) u_gate (
    .cnt  (line_cnt_i),
    .ofd  (ofd_d),
    .hclk (hclk_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rg_q   <= RG_BLANK;
      oh_q   <= '0;
      vten_q <= 1'b0;
      ofd_q  <= 1'b0;
      hclk_q <= 1'b0;
    end else begin
      rg_q   <= rg_d;
      oh_q   <= oh_d;
      vten_q <= |oh_d;
      ofd_q  <= ofd_d;
      hclk_q <= hclk_d;
    end
  end

  assign region_o   = rg_q;
  assign vt_stage_o = oh_q;
  assign vt_en_o    = vten_q;
  assign ofd_win_o  = ofd_q;
  assign hclk_en_o  = hclk_q;

endmodule

// File: rtl/seg_line_decoder_chk.sv
module seg_line_decoder_chk #(
  parameter int MAX_STAGES   = 4,
  parameter int FRAME_STAGES = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  frame_mode_i,
  input logic                  four_stage_i,
  input logic [1:0]            region_o,
  input logic [MAX_STAGES-1:0] vt_stage_o,
  input logic                  vt_en_o,
  input logic                  ofd_win_o,
  input logic                  hclk_en_o
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (region_o == 2'd0 && vt_stage_o == '0 && !vt_en_o && !ofd_win_o && !hclk_en_o));

  p_field3_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(frame_mode_i) && !$past(four_stage_i)) |-> ((vt_stage_o >> (MAX_STAGES-1)) == '0));

  p_frame_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_mode_i) |-> ((vt_stage_o >> FRAME_STAGES) == '0));

  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vt_stage_o));

  p_en_matches_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vt_en_o == (vt_stage_o != '0));

  p_active_shifts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (region_o == 2'd3) |-> hclk_en_o);

  p_no_shift_in_vt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vt_en_o |-> !hclk_en_o);

  p_ofd_in_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ofd_win_o |-> (!hclk_en_o && region_o == 2'd0));

endmodule

bind seg_line_decoder seg_line_decoder_chk #(
  .MAX_STAGES(MAX_STAGES), .FRAME_STAGES(FRAME_STAGES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_mode_i (frame_mode_i),
  .four_stage_i (four_stage_i),
  .region_o     (region_o),
  .vt_stage_o   (vt_stage_o),
  .vt_en_o      (vt_en_o),
  .ofd_win_o    (ofd_win_o),
  .hclk_en_o    (hclk_en_o)
);

// File: tb/seg_line_decoder_test.sv
`timescale 1ns/1ps
module seg_line_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cnt = 12'd0;
  logic        frame = 1'b0;
  logic        four = 1'b0;
  logic [1:0]  region;
  logic [3:0]  stage;
  logic        vt_en, ofd, hclk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  seg_line_decoder uut (
    .clk(clk), .rst_n(rst_n), .line_cnt_i(cnt), .frame_mode_i(frame),
    .four_stage_i(four), .region_o(region), .vt_stage_o(stage),
    .vt_en_o(vt_en), .ofd_win_o(ofd), .hclk_en_o(hclk)
  );

  typedef struct {
    int         c;
    bit         frame;
    bit         four;
    string      note;
    logic [1:0] tag;
    logic [3:0] oh;
    bit         ofd;
    bit         hclk;
  } exp_t;

  exp_t q[$];

  // expected values restated from the requirements
  function automatic exp_t model(int c, bit f, bit s, string note);
    exp_t e;
    int slot, n, st;
    e.c = c; e.frame = f; e.four = s; e.note = note;
    if (c < 54)                      e.tag = 2'd1;
    else if (c >= 278 && c < 302)    e.tag = 2'd2;
    else if (c == 302 || c == 303)   e.tag = 2'd1;
    else if (c >= 304 && c < 2400)   e.tag = 2'd3;
    else                             e.tag = 2'd0;
    slot = f ? 56 : 28;
    n    = f ? 3 : (s ? 4 : 3);
    st   = -1;
    if (c >= 54 && c < 54 + slot*n) st = (c - 54) / slot;
    e.oh   = (st >= 0) ? (4'b0001 << st) : 4'b0000;
    e.ofd  = (c >= 152 && c <= 207);
    e.hclk = (c <= 53) || (c >= 278 && c <= 2639);
    return e;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp, int c);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at count %0d: actual %0d expected %0d", req, c, act, exp);
    end
  endtask

  task automatic drive(int c, bit f, bit s, string note);
    @(negedge clk);
    cnt = 12'(c); frame = f; four = s;
    q.push_back(model(c, f, s, note));
  endtask

  // monitor: one expected item per cycle, sampled after the edge settles
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() != 0) begin
        exp_t e;
        string vreq;
        e = q.pop_front();
        vreq = e.frame ? "R6" : (e.four ? "R4" : "R5");
        chk(region == e.tag, {e.note, "R3 region"}, int'(region), int'(e.tag), e.c);
        chk(stage == e.oh, {e.note, vreq, " stage"}, int'(stage), int'(e.oh), e.c);
        chk(vt_en == (e.oh != 0), {e.note, "R7 vt_en"}, int'(vt_en), int'(e.oh != 0), e.c);
        chk(ofd == e.ofd, {e.note, "R8 ofd"}, int'(ofd), int'(e.ofd), e.c);
        chk(hclk == e.hclk, {e.note, "R9 hclk"}, int'(hclk), int'(e.hclk), e.c);
        chk(!(vt_en && hclk), {e.note, "R10 overlap"}, int'(vt_en && hclk), 0, e.c);
      end
    end
  end

  // watchdog
  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    // R1: reset held with an in-line count that would decode as optical black
    cnt = 12'd10; frame = 1'b0; four = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(region == 2'd0, "R1 region", int'(region), 0, 10);
    chk(stage == 4'd0 && !vt_en, "R1 stage", int'(stage), 0, 10);
    chk(!ofd && !hclk, "R1 ofd/hclk", int'({ofd, hclk}), 0, 10);
    cnt = 12'd160;
    @(negedge clk);
    chk(!ofd && !vt_en, "R1 count ignored", int'({ofd, vt_en}), 0, 160);
    rst_n = 1'b1;

    // full sweeps per timing variant
    for (int c = 0; c < 2640; c++) drive(c, 1'b0, 1'b1, "");   // R4 field, four stages
    for (int c = 0; c < 2640; c++) drive(c, 1'b0, 1'b0, "");   // R5 field, three stages
    for (int c = 0; c < 2640; c++) drive(c, 1'b1, 1'b0, "");   // R6 frame
    for (int c = 0; c < 2640; c++) drive(c, 1'b1, 1'b1, "");   // R6 select ignored
    // out-of-line counts fall back to blanking (R3, R9)
    for (int c = 2640; c < 4096; c += 7) drive(c, 1'b0, 1'b1, "");
    drive(4095, 1'b1, 1'b0, "");
    // R2: jumping counts with mode changing every cycle
    seed = 12345;
    for (int i = 0; i < 3000; i++) begin
      seed = seed * 1103515245 + 12345;
      drive((seed >>> 8) & 12'hFFF, seed[3], seed[5], "R2 ");
    end
    // R2: mode flip inside a transfer window
    drive(100, 1'b0, 1'b1, "R2 ");
    drive(101, 1'b1, 1'b1, "R2 ");
    drive(102, 1'b0, 1'b0, "R2 ");

    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule